// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Clear-on-Read Status

This block moves one byte at a time over a four-wire SPI link. It works either as the link master, generating the serial clock, or as a slave that follows a clock and select driven from outside. Software reaches it through a small 8-bit register bus with a 2-bit address, a read strobe, a write strobe and separate write and read data lines.

Three registers are visible:
- A control register sets enable, master and interrupt enable.
- A status register holds the sticky event flags, and any read of it wipes those flags.
- A data address accepts the byte to send on a write and returns the last received byte on a read.

The interrupt output tracks the completion flag when interrupts are enabled. The block flags a write that arrives mid-transfer. In master mode, it flags another master pulling its select line low.

The serial timing is fixed. SCK idles low. Bits travel MSB first. Outgoing data changes on the falling edge and incoming data is captured on the rising edge. In master mode the SCK period is `CLK_DIV` system clocks, where `CLK_DIV` is even and at least 4. In slave mode, SCK, MOSI and the select input pass through a synchronizer before they are used.

Top module: `spi_ctrl`

## Requirements
- R1: The status register sits at address 1. Bit 7 is transfer complete, bit 6 is write collision and bit 4 is mode fault. All three may be set at once.
- R2: Status bits 5 and 3..0 always read 0. After reset, the control and status registers both read 0x00.
- R3: A read of the status register clears bits 7, 6 and 4, so the next read returns 0 unless a new event has occurred.
- R4: In master mode, a write to address 2 while idle loads the byte and starts a transfer. The byte goes out on MOSI MSB first, and the byte arriving on MISO is captured MSB first.
- R5: At the end of every byte, the transfer-complete flag (status bit 7) is set, in both master and slave mode.
- R6: While status bit 7 is set and control bit 2 (interrupt enable) is 1, `irq_o` is high. With control bit 2 at 0, `irq_o` stays low.
- R7: A read of address 2 returns the last received byte, not the byte that was written to that address.
- R8: A write to address 2 while a transfer is in progress sets status bit 6. The written byte is discarded, and the byte being shifted is unchanged.
- R9: If `ss_ni` is low while the block is enabled as master, status bit 4 is set and control bit 1 (master) is cleared. Any transfer is abandoned, and `sck_oe_o` and `mosi_oe_o` drop to 0.
- R10: SCK idles low. During a master transfer, SCK is high for exactly 8 × `CLK_DIV`/2 system clocks. MOSI never changes while SCK is high.
- R11: In slave mode (control bit 1 = 0), with `ss_ni` low, `miso_o` is driven with output enable high. The preloaded byte goes out MSB first, and MOSI is sampled on each rising edge of `sck_i`.
- R12: Control register at address 0: bit 0 enables the block, bit 1 selects master, bit 2 enables the interrupt. While the block is disabled, a write to address 2 starts nothing, produces no SCK pulse and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; status clears at the edge ending the strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as `rd_i` |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe_o | output | 1 | Output enable for `sck_o` |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_oe_o | output | 1 | Output enable for `mosi_o` |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| miso_i | input | 1 | Serial data in for master mode |
| ss_ni | input | 1 | Slave select, active low; in master mode it signals a conflict |

## Verification
A wrong bit counter or a wrong divider count shows up at the pins within one transfer: the SCK high time differs from 8 × `CLK_DIV`/2, or the received byte comes back shifted. A status flag that stays stuck or fails to clear is exposed by the second of two consecutive status reads, a single bus cycle later. A shifter that a collided write has corrupted sends the wrong byte on MOSI in that same transfer. A mode fault that fails to release the pins shows as output enables that stay high a few cycles after `ss_ni` falls.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_DONE = 7;
  localparam int unsigned ST_WCOL = 6;
  localparam int unsigned ST_MODF = 4;

  typedef struct packed {
    logic irq_en;
    logic master;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              master_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              tick_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              ss_s_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              modf_o,
  output logic              sel_o,
  output logic              run_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ALL_BITS = 4'(BYTE_W);

  logic              busy_q, sck_q, sck_d_q, done_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] tx_q, rx_sh_q, rx_buf_q;
  logic              s_rise, s_fall, sel;

  assign sel    = enable_i && !master_i && !ss_s_i;
  assign modf_o = enable_i && master_i && !ss_s_i;
  assign s_rise = sck_s_i && !sck_d_q;
  assign s_fall = !sck_s_i && sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sck_q     <= 1'b0;
      sck_d_q   <= 1'b0;
      done_q    <= 1'b0;
      bit_cnt_q <= '0;
      tx_q      <= '0;
      rx_sh_q   <= '0;
      rx_buf_q  <= '0;
    end else begin
      sck_d_q <= sck_s_i;
      done_q  <= 1'b0;
      if (!enable_i || modf_o) begin
        busy_q    <= 1'b0;
        sck_q     <= 1'b0;
        bit_cnt_q <= '0;
      end else if (master_i) begin
        if (!busy_q) begin
          if (load_i) begin
            busy_q    <= 1'b1;
            tx_q      <= load_data_i;
            bit_cnt_q <= '0;
          end
        end else if (tick_i) begin
          if (!sck_q) begin
            // rising edge: capture MISO
            sck_q     <= 1'b1;
            rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], miso_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) rx_buf_q <= {rx_sh_q[BYTE_W-2:0], miso_i};
          end else begin
            // falling edge: advance MOSI
            sck_q <= 1'b0;
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            if (bit_cnt_q == ALL_BITS) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end else begin
        sck_q <= 1'b0;
        if (load_i) tx_q <= load_data_i;
        if (!sel) begin
          busy_q    <= 1'b0;
          bit_cnt_q <= '0;
        end else if (s_rise) begin
          rx_sh_q <= {rx_sh_q[BYTE_W-2:0], mosi_s_i};
          if (bit_cnt_q == LAST_BIT) begin
            rx_buf_q  <= {rx_sh_q[BYTE_W-2:0], mosi_s_i};
            done_q    <= 1'b1;
            busy_q    <= 1'b0;
            bit_cnt_q <= '0;
          end else begin
            busy_q    <= 1'b1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end else if (s_fall && busy_q) begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sel_o  = sel;
  assign run_o  = busy_q && master_i && enable_i;
  assign sck_o  = sck_q;
  assign sdo_o  = tx_q[BYTE_W-1];
  assign rx_o   = rx_buf_q;
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              modf_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_data_o
);
  ctrl_t ctrl_q;
  logic  done_q, wcol_q, modf_q;
  logic  wr_data, wr_ctrl, rd_stat, wcol_evt;

  assign wr_data  = wr_i && (addr_i == REG_DATA);
  assign wr_ctrl  = wr_i && (addr_i == REG_CTRL);
  assign rd_stat  = rd_i && (addr_i == REG_STAT);
  assign load_o   = wr_data && ctrl_q.enable && !busy_i;
  assign wcol_evt = wr_data && ctrl_q.enable && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      modf_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[2:0]);
      if (modf_i)  ctrl_q.master <= 1'b0;
      // a new event outranks the clearing read
      done_q <= done_i   || (done_q && !rd_stat);
      wcol_q <= wcol_evt || (wcol_q && !rd_stat);
      modf_q <= modf_i   || (modf_q && !rd_stat);
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_DONE] = done_q;
    status_o[ST_WCOL] = wcol_q;
    status_o[ST_MODF] = modf_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        REG_CTRL: rdata_o = {5'b0, ctrl_q};
        REG_STAT: rdata_o = status_o;
        REG_DATA: rdata_o = rx_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o       = done_q && ctrl_q.irq_en;
  assign ctrl_o      = ctrl_q;
  assign load_data_o = wdata_i;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  input  logic       miso_i,
  input  logic       ss_ni
);
  localparam int unsigned HALF = CLK_DIV / 2;

  ctrl_t       ctrl_w;
  logic [7:0]  status_w, rx_w, load_data_w;
  logic        busy_w, done_w, modf_w, sel_w, run_w, tick_w, load_w, sdo_w;
  logic        ss_s, sck_s, mosi_s;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, mosi_i}),
    .q_o   ({ss_s, sck_s, mosi_s})
  );

  spi_clk_div #(.HALF(HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_w),
    .tick_o(tick_w)
  );

  spi_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .busy_i     (busy_w),
    .done_i     (done_w),
    .modf_i     (modf_w),
    .rx_i       (rx_w),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .ctrl_o     (ctrl_w),
    .status_o   (status_w),
    .load_o     (load_w),
    .load_data_o(load_data_w)
  );

  spi_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (ctrl_w.enable),
    .master_i   (ctrl_w.master),
    .load_i     (load_w),
    .load_data_i(load_data_w),
    .tick_i     (tick_w),
    .sck_s_i    (sck_s),
    .mosi_s_i   (mosi_s),
    .ss_s_i     (ss_s),
    .miso_i     (miso_i),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .modf_o     (modf_w),
    .sel_o      (sel_w),
    .run_o      (run_w),
    .sck_o      (sck_o),
    .sdo_o      (sdo_w),
    .rx_o       (rx_w)
  );

  assign sck_oe_o  = ctrl_w.enable && ctrl_w.master;
  assign mosi_oe_o = ctrl_w.enable && ctrl_w.master;
  assign mosi_o    = sdo_w;
  assign miso_o    = sdo_w;
  assign miso_oe_o = sel_w;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
  import spi_ctrl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       sck_o,
  input logic       sck_oe_o,
  input logic       mosi_oe_o,
  input logic [7:0] status_w,
  input logic       busy_w,
  input logic       done_w,
  input ctrl_t      ctrl_w
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_STAT) |-> ((rdata_o & 8'h2F) == 8'h00));

  // R3
  clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_STAT && !done_w) |=> !status_w[ST_DONE]);

  // R5
  done_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> status_w[ST_DONE]);

  // R6
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_w && ctrl_w.irq_en && !(wr_i && addr_i == REG_CTRL)) |=> irq_o);

  // R8
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DATA && ctrl_w.enable && busy_w) |=> status_w[ST_WCOL]);

  // R9
  modf_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_w[ST_MODF]) |-> (!sck_oe_o && !mosi_oe_o));

  // R10
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_w |-> !sck_o);
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .sck_o    (sck_o),
  .sck_oe_o (sck_oe_o),
  .mosi_oe_o(mosi_oe_o),
  .status_w (status_w),
  .busy_w   (busy_w),
  .done_w   (done_w),
  .ctrl_w   (ctrl_w)
);

// File: tb/sim_spi_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ctrl;
  localparam int DIV   = 8;
  localparam int HALFB = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_ni = 1'b1;

  int n_chk = 0, n_fail = 0, hi_cnt = 0, mchg = 0;
  bit done_flag = 0;
  logic sck_prev = 1'b0, mosi_prev = 1'b0;

  always #10 clk = ~clk;

  spi_ctrl #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .miso_i(miso_i), .ss_ni(ss_ni)
  );

  always @(negedge clk) begin
    if (sck_o) hi_cnt++;
    if (sck_o && sck_prev && (mosi_o !== mosi_prev)) mchg++;
    sck_prev  = sck_o;
    mosi_prev = mosi_o;
  end

  function automatic logic [7:0] stat_byte(input bit d, input bit w, input bit m);
    return {d, w, 1'b0, m, 4'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic slave_model(input logic [7:0] resp, output logic [7:0] got);
    miso_i = resp[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o); got[7-i] = mosi_o;
      @(negedge sck_o); if (i < 7) miso_i = resp[6-i];
    end
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] resp, output logic [7:0] got);
    hi_cnt = 0; mchg = 0;
    do_write(2'd2, tx);
    slave_model(resp, got);
    repeat (3) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] rx_drv, output logic [7:0] got);
    ss_ni = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosi_i = rx_drv[7-i];
      repeat (HALFB) @(negedge clk);
      got[7-i] = miso_o;
      sck_i = 1'b1;
      repeat (HALFB) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd, got, tx, resp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R12 reset state
    do_read(2'd0, rd); chk("R12 ctrl after reset", rd, 8'h00);
    do_read(2'd1, rd); chk("R2 status after reset", rd, 8'h00);
    chk("R12 no drive after reset", {irq_o, sck_oe_o, mosi_oe_o, miso_oe_o}, 4'b0);

    // R12 disabled block ignores data writes
    hi_cnt = 0;
    do_write(2'd2, 8'hC3);
    repeat (40) @(negedge clk);
    chk("R12 no sck while disabled", hi_cnt, 0);
    do_read(2'd1, rd); chk("R12 no flag while disabled", rd, 8'h00);

    // R4 R5 R7 R10 directed master byte, irq disabled
    do_write(2'd0, 8'h03);
    chk("R12 master drives pins", {sck_oe_o, mosi_oe_o}, 2'b11);
    master_xfer(8'hA5, 8'h5A, got);
    chk("R4 mosi byte", got, 8'hA5);
    chk("R10 sck high time", hi_cnt, 8 * DIV / 2);
    chk("R10 mosi stable while sck high", mchg, 0);
    chk("R10 sck idles low", sck_o, 1'b0);
    chk("R6 irq low when disabled", irq_o, 1'b0);
    do_read(2'd1, rd); chk("R5 master done flag", rd, stat_byte(1, 0, 0));
    chk("R2 reserved bits", rd & 8'h2F, 8'h00);
    do_read(2'd1, rd); chk("R3 cleared on read", rd, 8'h00);
    do_read(2'd2, rd); chk("R7 rx readback", rd, 8'h5A);

    // R4 R6 random master bytes with irq
    do_write(2'd0, 8'h07);
    for (int k = 0; k < 6; k++) begin
      tx = 8'($urandom); resp = 8'($urandom);
      master_xfer(tx, resp, got);
      chk("R4 mosi random", got, tx);
      chk("R6 irq raised", irq_o, 1'b1);
      do_read(2'd1, rd); chk("R5 done random", rd, stat_byte(1, 0, 0));
      chk("R6 irq cleared by read", irq_o, 1'b0);
      do_read(2'd2, rd); chk("R4 miso random", rd, resp);
    end

    // R8 collision: discarded, shifting byte intact; left pending for R1
    tx = 8'h3C; resp = 8'hE1; hi_cnt = 0;
    do_write(2'd2, tx);
    fork
      slave_model(resp, got);
      begin repeat (6) @(negedge clk); do_write(2'd2, 8'hFF); end
    join
    repeat (3) @(negedge clk);
    chk("R8 shifter unchanged", got, tx);

    // R9 mode fault
    ss_ni = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 pins released", {sck_oe_o, mosi_oe_o}, 2'b00);
    do_read(2'd0, rd); chk("R9 master bit cleared", rd, 8'h05);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    do_read(2'd1, rd); chk("R1 all three flags", rd, stat_byte(1, 1, 1));
    do_read(2'd1, rd); chk("R3 all flags cleared", rd, 8'h00);
    do_read(2'd2, rd); chk("R8 rx from collided xfer", rd, resp);

    // R8 next transfer uses fresh byte only
    do_write(2'd0, 8'h03);
    master_xfer(8'h96, 8'h69, got);
    chk("R8 following transfer", got, 8'h96);
    do_read(2'd1, rd); chk("R8 no stale wcol", rd, stat_byte(1, 0, 0));

    // R11 R5 slave mode
    do_write(2'd0, 8'h01);
    for (int k = 0; k < 3; k++) begin
      tx = (k == 0) ? 8'h81 : 8'($urandom);
      resp = (k == 0) ? 8'h7E : 8'($urandom);
      do_write(2'd2, tx);
      ss_ni = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 miso enabled", miso_oe_o, 1'b1);
      ss_ni = 1'b1;
      slave_xfer(resp, got);
      chk("R11 miso byte", got, tx);
      do_read(2'd1, rd); chk("R5 slave done flag", rd, stat_byte(1, 0, 0));
      do_read(2'd2, rd); chk("R11 mosi captured", rd, resp);
    end
    chk("R11 miso released", miso_oe_o, 1'b0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule